// File: doc/BRIEF.md
# Parallel Sampling-ADC Host Controller

This block runs an external eight-channel, 8-bit sampling converter that has a parallel bus. A client asks for a sample by presenting a 3-bit channel number on a valid/ready request port. The controller drives the converter's channel address lines and its active-low convert-start line. It then waits for the converter's active-low end-of-conversion line to fall, and reads the 8-bit straight-binary word with chip-select and read pulled low together. The word comes back on a one-cycle valid output, tagged with the channel it was taken from.

The controller also handles the converter's timing rules. The converter powers up asleep, so the first request raises convert-start and holds it high for a wake-up interval before the first falling edge. A change of channel inserts an acquisition wait before the conversion starts. A missing end-of-conversion ends the request with an error pulse. A supply-fault pulse from an outside monitor makes the next two finished conversions be read but thrown away. In an optional mode, convert-start is left low after each conversion, so the converter powers down by itself between samples. All intervals are parameters counted in clock cycles.

Top module: `adc_host`

## Requirements
- R1: While reset is asserted, convStN is low (converter asleep), csN and rdN are high, reqReady is high, and outValid and timeoutErr are low.
- R2: When convStN is low while idle (asleep), an accepted request first drives convStN high and keeps it high for at least WAKE_CYC cycles before the falling edge that starts the conversion.
- R3: When the requested channel differs from the current chanAddr, at least ACQ_CYC cycles pass between the chanAddr update and the falling edge of convStN. For the same channel on an awake converter, convStN falls on the clock edge that accepts the request.
- R4: A conversion is started by driving convStN low for exactly PULSE_CYC cycles. When autoPowerDown is 0 it then returns high. No read strobe is active at a convStN falling edge.
- R5: The read happens only after a falling edge of the synchronized eocN is seen while waiting. csN and rdN go low together for exactly READ_CYC cycles.
- R6: A kept result appears as a single-cycle outValid. outData equals the bus word read, and outChan equals the requested channel.
- R7: If eocN does not fall within TIMEOUT_CYC cycles after the convert-start pulse ends, timeoutErr pulses for one cycle, no outValid is produced, and reqReady returns high.
- R8: After a brownOut pulse, the next two completed conversions produce no outValid. The third one does.
- R9: A request is taken only while reqReady is high. While busy, reqValid and reqChan have no effect, and chanAddr changes only when a request is accepted.
- R10: With autoPowerDown at 1, convStN stays low after the conversion. The next request then raises it for the wake-up interval (as in R2) before converting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Sample request present |
| reqChan | input | 3 | Channel to sample |
| reqReady | output | 1 | Controller idle, request can be taken |
| autoPowerDown | input | 1 | 1: leave convStN low after each conversion |
| brownOut | input | 1 | Supply-fault pulse; discard next two results |
| chanAddr | output | 3 | Converter channel address lines |
| convStN | output | 1 | Convert-start, active low |
| csN | output | 1 | Chip select, active low |
| rdN | output | 1 | Read strobe, active low |
| eocN | input | 1 | End of conversion, active low, asynchronous |
| dataBus | input | 8 | Converter data bus |
| outValid | output | 1 | Result valid, one cycle |
| outData | output | 8 | Result word, straight binary |
| outChan | output | 3 | Channel tag of the result |
| timeoutErr | output | 1 | One-cycle pulse on conversion timeout |

## Verification
Some properties are checked on every cycle: outValid and timeoutErr are single-cycle pulses, the read strobes stay high whenever the controller is idle, no read is active when convert-start falls, and chanAddr holds except on an accepted request. The interval lengths can only be shown by the bench's scenarios, against a model converter that answers each convert-start: the wake-up hold, the acquisition wait, the convert pulse width and the read width. The same holds for the discard count after a brownOut pulse, the timeout path, the power-down mode and the values and tags of the words returned.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAKE,
    ST_ACQ,
    ST_CONV,
    ST_WAIT,
    ST_READ
  } ctlState_e;

  // strobes from the control path to the datapath
  typedef struct packed {
    logic loadChan;  // latch requested channel onto the address lines
    logic capture;   // latch bus word and tag at end of read
    logic keep;      // captured word is delivered (not a recovery discard)
  } dpStrobe_t;

  localparam int RECOVERY_CONVS = 2;

endpackage

// File: rtl/adc_host_dp.sv
module adc_host_dp
  import adc_host_pkg::*;
#(
  parameter int CHAN_W      = 3,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [CHAN_W-1:0] reqChan,
  input  logic              eocN,
  input  logic [DATA_W-1:0] dataBus,
  output logic              chanDiffers,
  output logic              eocFall,
  output logic [CHAN_W-1:0] chanAddr,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic [CHAN_W-1:0] outChan
);

  // synchronizer stages plus one history flop for edge detection
  logic [SYNC_STAGES:0] eocPipe;

  always_ff @(posedge clk) begin
    if (!rstN) eocPipe <= '1;
    else       eocPipe <= {eocPipe[SYNC_STAGES-1:0], eocN};
  end

  assign eocFall     = eocPipe[SYNC_STAGES] & ~eocPipe[SYNC_STAGES-1];
  assign chanDiffers = (reqChan != chanAddr);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chanAddr <= '0;
      outValid <= 1'b0;
      outData  <= '0;
      outChan  <= '0;
    end else begin
      if (strobe.loadChan) chanAddr <= reqChan;
      outValid <= strobe.capture & strobe.keep;
      if (strobe.capture) begin
        outData <= dataBus;
        outChan <= chanAddr;
      end
    end
  end

  // R6: a result is announced for one cycle only
  a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  // R9: address lines move only on an accepted request
  a_r9_chan_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadChan |=> $stable(chanAddr));

endmodule

// File: rtl/adc_host_ctl.sv
module adc_host_ctl
  import adc_host_pkg::*;
#(
  parameter int PULSE_CYC   = 3,
  parameter int ACQ_CYC     = 16,
  parameter int WAKE_CYC    = 20,
  parameter int TIMEOUT_CYC = 60,
  parameter int READ_CYC    = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  output logic      reqReady,
  input  logic      chanDiffers,
  input  logic      eocFall,
  input  logic      autoPowerDown,
  input  logic      brownOut,
  output logic      convStN,
  output logic      csN,
  output logic      rdN,
  output logic      timeoutErr,
  output dpStrobe_t strobe
);

  localparam int MAX_A   = (WAKE_CYC > ACQ_CYC) ? WAKE_CYC : ACQ_CYC;
  localparam int MAX_B   = (TIMEOUT_CYC > PULSE_CYC) ? TIMEOUT_CYC : PULSE_CYC;
  localparam int MAX_C   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_MAX = (MAX_C > READ_CYC) ? MAX_C : READ_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int DSC_W   = $clog2(RECOVERY_CONVS + 1);

  ctlState_e        state;
  logic [CNT_W-1:0] cnt;
  logic             acqPend;
  logic             convStNq;
  logic             readActN;
  logic [DSC_W-1:0] discardCnt;
  logic             cntDone;

  assign cntDone  = (cnt == '0);
  assign reqReady = (state == ST_IDLE);
  assign convStN  = convStNq;
  assign csN      = readActN;
  assign rdN      = readActN;

  always_comb begin
    strobe          = '0;
    strobe.loadChan = (state == ST_IDLE) && reqValid;
    strobe.capture  = (state == ST_READ) && cntDone;
    strobe.keep     = (discardCnt == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      acqPend    <= 1'b0;
      convStNq   <= 1'b0;
      readActN   <= 1'b1;
      timeoutErr <= 1'b0;
      discardCnt <= '0;
    end else begin
      timeoutErr <= 1'b0;
      if (brownOut)
        discardCnt <= DSC_W'(RECOVERY_CONVS);
      else if (strobe.capture && discardCnt != '0)
        discardCnt <= discardCnt - 1'b1;

      unique case (state)
        ST_IDLE: if (reqValid) begin
          acqPend <= chanDiffers;
          if (!convStNq) begin
            state    <= ST_WAKE;
            convStNq <= 1'b1;
            cnt      <= CNT_W'(WAKE_CYC - 1);
          end else if (chanDiffers) begin
            state <= ST_ACQ;
            cnt   <= CNT_W'(ACQ_CYC - 1);
          end else begin
            state    <= ST_CONV;
            convStNq <= 1'b0;
            cnt      <= CNT_W'(PULSE_CYC - 1);
          end
        end
        ST_WAKE: begin
          if (!cntDone) cnt <= cnt - 1'b1;
          else if (acqPend) begin
            state <= ST_ACQ;
            cnt   <= CNT_W'(ACQ_CYC - 1);
          end else begin
            state    <= ST_CONV;
            convStNq <= 1'b0;
            cnt      <= CNT_W'(PULSE_CYC - 1);
          end
        end
        ST_ACQ: begin
          if (!cntDone) cnt <= cnt - 1'b1;
          else begin
            state    <= ST_CONV;
            convStNq <= 1'b0;
            cnt      <= CNT_W'(PULSE_CYC - 1);
          end
        end
        ST_CONV: begin
          if (!cntDone) cnt <= cnt - 1'b1;
          else begin
            if (!autoPowerDown) convStNq <= 1'b1;
            state <= ST_WAIT;
            cnt   <= CNT_W'(TIMEOUT_CYC - 1);
          end
        end
        ST_WAIT: begin
          if (eocFall) begin
            state    <= ST_READ;
            readActN <= 1'b0;
            cnt      <= CNT_W'(READ_CYC - 1);
          end else if (cntDone) begin
            timeoutErr <= 1'b1;
            state      <= ST_IDLE;
          end else cnt <= cnt - 1'b1;
        end
        ST_READ: begin
          if (!cntDone) cnt <= cnt - 1'b1;
          else begin
            readActN <= 1'b1;
            state    <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7: the timeout flag never stretches
  a_r7_err_single: assert property (@(posedge clk) disable iff (!rstN)
    timeoutErr |=> !timeoutErr);

  // R9: no read strobe while the request port is open
  a_r9_ready_quiet: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (csN && rdN));

  // R4: a conversion never starts under an active read
  a_r4_fall_no_read: assert property (@(posedge clk) disable iff (!rstN)
    $fell(convStN) |-> csN);

endmodule

// File: rtl/adc_host.sv
module adc_host
  import adc_host_pkg::*;
#(
  parameter int CHAN_W      = 3,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int PULSE_CYC   = 3,
  parameter int ACQ_CYC     = 16,
  parameter int WAKE_CYC    = 20,
  parameter int TIMEOUT_CYC = 60,
  parameter int READ_CYC    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [CHAN_W-1:0] reqChan,
  output logic              reqReady,
  input  logic              autoPowerDown,
  input  logic              brownOut,
  output logic [CHAN_W-1:0] chanAddr,
  output logic              convStN,
  output logic              csN,
  output logic              rdN,
  input  logic              eocN,
  input  logic [DATA_W-1:0] dataBus,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic [CHAN_W-1:0] outChan,
  output logic              timeoutErr
);

  dpStrobe_t strobe;
  logic      chanDiffers;
  logic      eocFall;

  adc_host_ctl #(
    .PULSE_CYC  (PULSE_CYC),
    .ACQ_CYC    (ACQ_CYC),
    .WAKE_CYC   (WAKE_CYC),
    .TIMEOUT_CYC(TIMEOUT_CYC),
    .READ_CYC   (READ_CYC)
  ) u_ctl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .reqReady     (reqReady),
    .chanDiffers  (chanDiffers),
    .eocFall      (eocFall),
    .autoPowerDown(autoPowerDown),
    .brownOut     (brownOut),
    .convStN      (convStN),
    .csN          (csN),
    .rdN          (rdN),
    .timeoutErr   (timeoutErr),
    .strobe       (strobe)
  );

  adc_host_dp #(
    .CHAN_W     (CHAN_W),
    .DATA_W     (DATA_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqChan    (reqChan),
    .eocN       (eocN),
    .dataBus    (dataBus),
    .chanDiffers(chanDiffers),
    .eocFall    (eocFall),
    .chanAddr   (chanAddr),
    .outValid   (outValid),
    .outData    (outData),
    .outChan    (outChan)
  );

endmodule

// File: tb/sim_adc_host.sv
`timescale 1ns/1ps
module sim_adc_host;

  localparam int PULSE_CYC   = 3;
  localparam int ACQ_CYC     = 16;
  localparam int WAKE_CYC    = 20;
  localparam int TIMEOUT_CYC = 60;
  localparam int READ_CYC    = 2;
  localparam int EOC_DELAY   = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic [2:0] reqChan = '0;
  logic       reqReady;
  logic       autoPowerDown = 1'b0;
  logic       brownOut = 1'b0;
  logic [2:0] chanAddr;
  logic       convStN, csN, rdN;
  logic       eocN = 1'b1;
  logic [7:0] dataBus = '0;
  logic       outValid;
  logic [7:0] outData;
  logic [2:0] outChan;
  logic       timeoutErr;

  always #4 clk = ~clk;  // 125 MHz

  adc_host #(
    .PULSE_CYC(PULSE_CYC), .ACQ_CYC(ACQ_CYC), .WAKE_CYC(WAKE_CYC),
    .TIMEOUT_CYC(TIMEOUT_CYC), .READ_CYC(READ_CYC)
  ) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqChan(reqChan),
    .reqReady(reqReady), .autoPowerDown(autoPowerDown), .brownOut(brownOut),
    .chanAddr(chanAddr), .convStN(convStN), .csN(csN), .rdN(rdN),
    .eocN(eocN), .dataBus(dataBus), .outValid(outValid), .outData(outData),
    .outChan(outChan), .timeoutErr(timeoutErr)
  );

  int nChecks = 0;
  int nFails  = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ---------------- converter model and port monitor ----------------
  int         cyc = 0;
  logic       prevConv = 1'b0, prevCs = 1'b1;
  logic [2:0] prevChan = '0;
  int riseCyc = 0, chanCyc = 0, acceptCyc = 0, lowRun = 0, csRun = 0;
  int lastWakeGap = 0, lastAcqGap = 0, lastStartLat = 0, lastLowRun = 0, lastCsRun = 0;
  int validCnt = 0, errCnt = 0, pairBad = 0, eocDelay = -1;
  logic [7:0] lastData = '0;
  logic [2:0] lastChan = '0;
  logic       modelOn = 1'b1;
  logic [7:0] pattern = '0;

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (!rstN) begin
      eocN     <= 1'b1;
      eocDelay = -1;
      lowRun   = 0;
      prevConv = convStN;
      prevCs   = 1'b1;
      prevChan = chanAddr;
    end else begin
      if (eocDelay == 0) begin
        eocN    <= 1'b0;
        dataBus <= pattern ^ {5'b0, chanAddr};
        eocDelay = -1;
      end else if (eocDelay > 0) eocDelay = eocDelay - 1;
      if (!prevCs && csN) eocN <= 1'b1;
      if (reqValid && reqReady) acceptCyc = cyc;
      if (chanAddr != prevChan) chanCyc = cyc;
      if (!prevConv && convStN) riseCyc = cyc;
      if (prevConv && !convStN) begin
        lastWakeGap  = cyc - riseCyc;
        lastAcqGap   = cyc - chanCyc;
        lastStartLat = cyc - acceptCyc;
        if (modelOn) eocDelay = EOC_DELAY;
      end
      if (!convStN) lowRun = lowRun + 1;
      else if (!prevConv) begin lastLowRun = lowRun; lowRun = 0; end
      if (!csN) csRun = csRun + 1;
      else if (!prevCs) begin lastCsRun = csRun; csRun = 0; end
      if (csN != rdN) pairBad = pairBad + 1;
      if (outValid) begin
        validCnt = validCnt + 1;
        lastData = outData;
        lastChan = outChan;
      end
      if (timeoutErr) errCnt = errCnt + 1;
      prevConv = convStN;
      prevCs   = csN;
      prevChan = chanAddr;
    end
  end

  // ---------------- helpers ----------------
  task automatic doReq(input logic [2:0] ch);
    @(negedge clk);
    for (int i = 0; i < 500 && !reqReady; i++) @(negedge clk);
    reqValid = 1'b1;
    reqChan  = ch;
    @(negedge clk);
    reqValid = 1'b0;
    for (int i = 0; i < 500 && !reqReady; i++) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  // ---------------- scenarios ----------------
  task automatic tReset();
    repeat (3) @(negedge clk);
    chk(convStN == 1'b0, "R1 convStN low in reset", convStN, 0);
    chk(csN && rdN, "R1 strobes high in reset", {csN, rdN}, 3);
    chk(reqReady == 1'b1, "R1 ready in reset", reqReady, 1);
    chk(!outValid && !timeoutErr, "R1 outputs quiet in reset", {outValid, timeoutErr}, 0);
    rstN = 1'b1;
  endtask

  task automatic tFirstWake();
    int v0;
    pattern = 8'h00;
    v0 = validCnt;
    doReq(3'd0);
    chk(lastWakeGap >= WAKE_CYC, "R2 wake hold before first convert", lastWakeGap, WAKE_CYC);
    chk(validCnt == v0 + 1, "R6 one result", validCnt - v0, 1);
    chk(lastData == 8'h00, "R6 zero code", lastData, 0);
    chk(lastChan == 3'd0, "R6 tag", lastChan, 0);
    chk(lastCsRun == READ_CYC, "R5 read width", lastCsRun, READ_CYC);
    chk(pairBad == 0, "R5 cs and rd together", pairBad, 0);
  endtask

  task automatic tSameChan();
    pattern = 8'hFF;
    doReq(3'd0);
    chk(lastStartLat == 1, "R3 no wait on same channel", lastStartLat, 1);
    chk(lastLowRun == PULSE_CYC, "R4 convert pulse width", lastLowRun, PULSE_CYC);
    chk(convStN == 1'b1, "R4 convStN back high", convStN, 1);
    chk(lastData == 8'hFF, "R6 full-scale code", lastData, 255);
  endtask

  task automatic tChanChange();
    pattern = 8'hA5;
    doReq(3'd5);
    chk(lastAcqGap >= ACQ_CYC, "R3 acquisition wait", lastAcqGap, ACQ_CYC);
    chk(lastData == 8'hA0, "R6 data on new channel", lastData, 8'hA0);
    chk(lastChan == 3'd5, "R6 tag new channel", lastChan, 5);
    chk(chanAddr == 3'd5, "R3 address lines", chanAddr, 5);
  endtask

  task automatic tTimeout();
    int v0, e0;
    modelOn = 1'b0;
    v0 = validCnt;
    e0 = errCnt;
    doReq(3'd5);
    chk(errCnt == e0 + 1, "R7 timeout flagged once", errCnt - e0, 1);
    chk(validCnt == v0, "R7 no result on timeout", validCnt - v0, 0);
    chk(reqReady == 1'b1, "R7 ready after timeout", reqReady, 1);
    modelOn = 1'b1;
  endtask

  task automatic tBrownout();
    int v0;
    pattern = 8'h3C;
    @(negedge clk); brownOut = 1'b1;
    @(negedge clk); brownOut = 1'b0;
    v0 = validCnt;
    doReq(3'd1);
    chk(validCnt == v0, "R8 first recovery discarded", validCnt - v0, 0);
    doReq(3'd1);
    chk(validCnt == v0, "R8 second recovery discarded", validCnt - v0, 0);
    doReq(3'd1);
    chk(validCnt == v0 + 1, "R8 third delivered", validCnt - v0, 1);
    chk(lastData == 8'h3D, "R8 delivered word", lastData, 8'h3D);
  endtask

  task automatic tBusy();
    bit held = 1'b1;
    pattern = 8'h81;
    @(negedge clk);
    for (int i = 0; i < 500 && !reqReady; i++) @(negedge clk);
    reqValid = 1'b1;
    reqChan  = 3'd4;
    @(negedge clk);
    reqChan = 3'd7;
    for (int i = 0; i < 6; i++) begin
      if (reqReady || chanAddr != 3'd4) held = 1'b0;
      @(negedge clk);
    end
    reqValid = 1'b0;
    for (int i = 0; i < 500 && !reqReady; i++) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(held, "R9 busy request ignored", chanAddr, 4);
    chk(lastChan == 3'd4, "R9 tag of accepted request", lastChan, 4);
    chk(lastData == 8'h85, "R9 data of accepted request", lastData, 8'h85);
  endtask

  task automatic tAutoPd();
    int v0;
    autoPowerDown = 1'b1;
    pattern = 8'h10;
    v0 = validCnt;
    doReq(3'd2);
    chk(validCnt == v0 + 1, "R10 result in power-down mode", validCnt - v0, 1);
    chk(convStN == 1'b0, "R10 convStN left low", convStN, 0);
    doReq(3'd2);
    chk(lastWakeGap >= WAKE_CYC, "R10 wake before next convert", lastWakeGap, WAKE_CYC);
    chk(lastData == 8'h12, "R10 data after wake", lastData, 8'h12);
    autoPowerDown = 1'b0;
    doReq(3'd2);
    chk(convStN == 1'b1, "R10 normal mode restores idle high", convStN, 1);
  endtask

  // ---------------- watchdog and sequence ----------------
  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    tReset();
    tFirstWake();
    tSameChan();
    tChanChange();
    tTimeout();
    tBrownout();
    tBusy();
    tAutoPd();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule